// File: doc/BRIEF.md
# Whole-Display Brightness Fade Sequencer

This block produces one brightness scale factor for an entire LED matrix. It is a level from 0 to 63. The PWM stage downstream uses it to multiply or cap the duty of every dot. When a start strobe arrives, the level ramps one step at a time through all 64 values, either upward (brightening) or downward (dimming). The time between steps comes from a 4-bit speed code and a free-running millisecond tick: each step waits (code+1)×2 ticks. A complete ramp therefore takes between 126 ms and 2016 ms.

Fading is armed before it is started. Enabling the block with the upward direction selected blanks the display at once, so a following start ramps up from darkness with no visible flash. In single mode the ramp stops at its end level and holds there. In looping mode it reverses at each end and keeps going back and forth. Each arrival at an end level sets a completion flag. The flag stays set until a clear strobe removes it. While the block is disabled the level sits at full scale, and the display runs at its normal brightness.

Top module: `fade_sequencer`

## Requirements
- R1: While `fade_en` is 0, `fade_level` is 63 and `force_off` is 0, and a `fade_go` strobe has no effect.
- R2: Once enabled and not yet started, the block blanks the display if `fade_out` is 0 (`force_off` = 1 and `fade_level` = 0). If `fade_out` is 1, the level stays at 63 and `force_off` is 0.
- R3: A `fade_go` strobe while enabled starts a ramp from the start level for the selected direction: 0 when `fade_out` = 0, 63 when `fade_out` = 1. The level then changes by exactly one per step.
- R4: A step happens when (`fade_speed`+1)×2 `ms_tick` cycles have been counted since the start or since the previous step. With no ticks, no step happens.
- R5: With `fade_loop` = 0, the ramp stops at its end level (63 upward, 0 downward). The level then holds until a new start or until the block is disabled.
- R6: With `fade_loop` = 1, the direction reverses at each end level and the ramp continues without a stop.
- R7: `done_flag` is set in the cycle the level reaches an end level. It stays set until a `done_clr` strobe, which clears it.
- R8: If the final step of a ramp and a `done_clr` strobe fall in the same cycle, `done_flag` ends that cycle set.
- R9: A `fade_go` strobe while a ramp is running restarts it from the start level and restarts the step interval.
- R10: After reset, `fade_level` is 63, `force_off` is 0 and `done_flag` is 0.

Handshake rule: `fade_go` and `done_clr` are strobes; each strobe is one clock cycle wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| fade_en | input | 1 | Fading enabled |
| fade_go | input | 1 | Start strobe |
| fade_out | input | 1 | Direction: 0 brightens, 1 dims |
| fade_loop | input | 1 | 0 single ramp, 1 back-and-forth |
| fade_speed | input | SPEED_W | Step interval code |
| done_clr | input | 1 | Completion flag clear strobe |
| fade_level | output | 6 | Current brightness scale, 63 = full |
| force_off | output | 1 | Blank all matrix LEDs |
| done_flag | output | 1 | Sticky completion flag |

## Verification
Two functions can fall in the same cycle: the step that brings the level to its end and a software clear of the completion flag. The bench counts clock edges from the start strobe. It times the clear so that it is sampled on the exact edge of the 63rd step. The run passes only if the flag reads set afterwards, and a later lone clear then empties it. A second coincidence is a new start during a running ramp. The bench judges it by the jump back to the start level and by the full interval that follows before the next step.

// File: rtl/fade_pkg.sv
package fade_pkg;
    localparam int unsigned FADE_LEVEL_W = 6;

    typedef enum logic [1:0] {
        FS_IDLE  = 2'd0,
        FS_ARMED = 2'd1,
        FS_RUN   = 2'd2,
        FS_HOLD  = 2'd3
    } fade_state_e;

    typedef struct packed {
        fade_state_e             state;
        logic [FADE_LEVEL_W-1:0] level;
        logic                    dir_down;
        logic                    dark;
    } fade_regs_t;
endpackage

// File: rtl/fade_step_timer.sv
module fade_step_timer #(
    parameter int unsigned SPEED_W     = 4,
    parameter int unsigned MS_PER_UNIT = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic               restart,
    input  logic               ms_tick,
    input  logic [SPEED_W-1:0] speed,
    output logic               step
);
    localparam int unsigned MAX_TICKS = (2 ** SPEED_W) * MS_PER_UNIT;
    localparam int unsigned CNT_W     = $clog2(MAX_TICKS + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] limit;
    logic             reached;

    always_comb begin
        limit   = CNT_W'((int'(speed) + 1) * MS_PER_UNIT);
        reached = (cnt_q + CNT_W'(1)) >= limit;
        step    = run && !restart && ms_tick && reached;
        cnt_d   = cnt_q;
        if (!run || restart) begin
            cnt_d = '0;
        end else if (ms_tick) begin
            cnt_d = reached ? '0 : cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/fade_level_step.sv
module fade_level_step #(
    parameter int unsigned LEVEL_W = 6
) (
    input  logic [LEVEL_W-1:0] level,
    input  logic               dir_down,
    output logic [LEVEL_W-1:0] next_level,
    output logic               at_end
);
    localparam logic [LEVEL_W-1:0] TOP = {LEVEL_W{1'b1}};

    always_comb begin
        if (dir_down) begin
            next_level = level - LEVEL_W'(1);
            at_end     = (level == LEVEL_W'(1));
        end else begin
            next_level = level + LEVEL_W'(1);
            at_end     = (level == TOP - LEVEL_W'(1));
        end
    end
endmodule

// File: rtl/fade_done_latch.sv
module fade_done_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);
    logic flag_d, flag_q;

    always_comb begin
        flag_d = set | (flag_q & ~clr);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign flag = flag_q;
endmodule

// File: rtl/fade_sequencer.sv
module fade_sequencer
    import fade_pkg::*;
#(
    parameter int unsigned SPEED_W     = 4,
    parameter int unsigned MS_PER_UNIT = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ms_tick,
    input  logic                    fade_en,
    input  logic                    fade_go,
    input  logic                    fade_out,
    input  logic                    fade_loop,
    input  logic [SPEED_W-1:0]      fade_speed,
    input  logic                    done_clr,
    output logic [FADE_LEVEL_W-1:0] fade_level,
    output logic                    force_off,
    output logic                    done_flag
);
    localparam logic [FADE_LEVEL_W-1:0] LVL_MAX = {FADE_LEVEL_W{1'b1}};
    localparam logic [FADE_LEVEL_W-1:0] LVL_MIN = '0;

    fade_regs_t  cur_q, nxt_d;
    fade_state_e state_q;
    logic        step;
    logic        at_end;
    logic        done_set;
    logic [FADE_LEVEL_W-1:0] ramp_next;

    fade_step_timer #(
        .SPEED_W     (SPEED_W),
        .MS_PER_UNIT (MS_PER_UNIT)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (cur_q.state == FS_RUN),
        .restart (fade_go),
        .ms_tick (ms_tick),
        .speed   (fade_speed),
        .step    (step)
    );

    fade_level_step #(
        .LEVEL_W (FADE_LEVEL_W)
    ) u_ramp (
        .level      (cur_q.level),
        .dir_down   (cur_q.dir_down),
        .next_level (ramp_next),
        .at_end     (at_end)
    );

    always_comb begin
        nxt_d    = cur_q;
        done_set = 1'b0;
        if (!fade_en) begin
            nxt_d.state    = FS_IDLE;
            nxt_d.level    = LVL_MAX;
            nxt_d.dir_down = 1'b0;
            nxt_d.dark     = 1'b0;
        end else if (fade_go) begin
            nxt_d.state    = FS_RUN;
            nxt_d.dir_down = fade_out;
            nxt_d.level    = fade_out ? LVL_MAX : LVL_MIN;
            nxt_d.dark     = 1'b0;
        end else begin
            unique case (cur_q.state)
                FS_IDLE, FS_ARMED: begin
                    nxt_d.state    = FS_ARMED;
                    nxt_d.dir_down = fade_out;
                    nxt_d.level    = fade_out ? LVL_MAX : LVL_MIN;
                    nxt_d.dark     = !fade_out;
                end
                FS_RUN: begin
                    if (step) begin
                        nxt_d.level = ramp_next;
                        if (at_end) begin
                            done_set = 1'b1;
                            if (fade_loop) nxt_d.dir_down = ~cur_q.dir_down;
                            else           nxt_d.state    = FS_HOLD;
                        end
                    end
                end
                FS_HOLD: begin
                    nxt_d = cur_q;
                end
                default: begin
                    nxt_d.state = FS_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q.state    <= FS_IDLE;
            cur_q.level    <= LVL_MAX;
            cur_q.dir_down <= 1'b0;
            cur_q.dark     <= 1'b0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    fade_done_latch u_done (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (done_set),
        .clr   (done_clr),
        .flag  (done_flag)
    );

    assign state_q    = cur_q.state;
    assign fade_level = cur_q.level;
    assign force_off  = cur_q.dark;
endmodule

// File: rtl/fade_sequencer_chk.sv
module fade_sequencer_chk
    import fade_pkg::*;
(
    input logic                    clk,
    input logic                    rst_n,
    input logic                    fade_en,
    input logic                    fade_go,
    input logic                    done_clr,
    input logic [FADE_LEVEL_W-1:0] fade_level,
    input logic                    force_off,
    input logic                    done_flag,
    input fade_state_e             state_q
);
    localparam logic [FADE_LEVEL_W-1:0] TOP = {FADE_LEVEL_W{1'b1}};

    // R1
    disabled_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!fade_en) |-> (fade_level == TOP && !force_off));

    // R2
    dark_is_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        force_off |-> fade_level == '0);

    // R3
    unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fade_en && !fade_go && state_q == FS_RUN) |=>
        ({1'b0, fade_level} == $past({1'b0, fade_level}) ||
         {1'b0, fade_level} == $past({1'b0, fade_level}) + 7'd1 ||
         {1'b0, fade_level} + 7'd1 == $past({1'b0, fade_level})));

    // R5
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fade_en && !fade_go && state_q == FS_HOLD) |=> $stable(fade_level));

    // R7
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_flag && !done_clr) |=> done_flag);

    // R7
    done_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_flag) |-> (fade_level == '0 || fade_level == TOP));

    // R7
    clear_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_clr && state_q != FS_RUN) |=> !done_flag);
endmodule

bind fade_sequencer fade_sequencer_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fade_en    (fade_en),
    .fade_go    (fade_go),
    .done_clr   (done_clr),
    .fade_level (fade_level),
    .force_off  (force_off),
    .done_flag  (done_flag),
    .state_q    (state_q)
);

// File: tb/sim_fade_sequencer.sv
`timescale 1ns/1ps
module sim_fade_sequencer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ms_tick = 1'b1;
    logic       fade_en = 1'b0;
    logic       fade_go = 1'b0;
    logic       fade_out = 1'b0;
    logic       fade_loop = 1'b0;
    logic [3:0] fade_speed = 4'd0;
    logic       done_clr = 1'b0;
    logic [5:0] fade_level;
    logic       force_off;
    logic       done_flag;

    int n_checks = 0;
    int n_fails  = 0;
    int edge_cnt = 0;
    bit finished = 1'b0;

    typedef struct { int level; int gap; } exp_t;
    exp_t exp_q[$];
    bit   mon_on = 1'b0;
    int   last_evt = 0;
    int   prev_lvl = -1;

    always #2.5 clk = ~clk;

    fade_sequencer u0 (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .fade_en(fade_en),
        .fade_go(fade_go), .fade_out(fade_out), .fade_loop(fade_loop),
        .fade_speed(fade_speed), .done_clr(done_clr),
        .fade_level(fade_level), .force_off(force_off), .done_flag(done_flag)
    );

    always @(posedge clk) edge_cnt <= edge_cnt + 1;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    endtask

    // monitor: pops expected ramp levels and step gaps
    always @(negedge clk) begin
        if (rst_n && int'(fade_level) != prev_lvl && prev_lvl >= 0 && mon_on) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R3 unexpected level change", int'(fade_level), prev_lvl);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(int'(fade_level) == e.level, "R3 level", int'(fade_level), e.level);
                check(edge_cnt - last_evt == e.gap, "R4 step gap", edge_cnt - last_evt, e.gap);
            end
            last_evt = edge_cnt;
        end
        prev_lvl = int'(fade_level);
    end

    task automatic push_ramp(input int first, input int last, input int gap);
        exp_t e;
        int dirv = (last >= first) ? 1 : -1;
        for (int v = first; v != last + dirv; v += dirv) begin
            e.level = v;
            e.gap   = gap;
            exp_q.push_back(e);
        end
    endtask

    task automatic pulse_go();
        @(negedge clk) fade_go = 1'b1;
        @(posedge clk);
        @(negedge clk) fade_go = 1'b0;
        last_evt = edge_cnt;
    endtask

    task automatic pulse_clr();
        @(negedge clk) done_clr = 1'b1;
        @(posedge clk);
        @(negedge clk) done_clr = 1'b0;
    endtask

    task automatic wait_drain();
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog", edge_cnt, 0);
        finish_run();
    end

    initial begin
        idle(4);
        rst_n = 1'b1;
        idle(1);
        // R10 reset state
        check(fade_level == 6'd63, "R10 level", fade_level, 63);
        check(force_off == 1'b0, "R10 force_off", force_off, 0);
        check(done_flag == 1'b0, "R10 done", done_flag, 0);

        // R1 start ignored while disabled
        pulse_go();
        idle(10);
        check(fade_level == 6'd63, "R1 level after ignored go", fade_level, 63);
        check(force_off == 1'b0, "R1 force_off", force_off, 0);

        // R2 armed fade-in blanks
        fade_en = 1'b1;
        idle(2);
        check(force_off == 1'b1, "R2 force_off armed up", force_off, 1);
        check(fade_level == 6'd0, "R2 level armed up", fade_level, 0);

        // R3 R4 R5 R7 single fade-in, speed 0
        push_ramp(1, 63, 2);
        mon_on = 1'b1;
        pulse_go();
        check(force_off == 1'b0, "R3 force_off after go", force_off, 0);
        wait_drain();
        mon_on = 1'b0;
        check(done_flag == 1'b1, "R7 done after fade-in", done_flag, 1);
        idle(40);
        check(fade_level == 6'd63, "R5 hold at top", fade_level, 63);
        check(done_flag == 1'b1, "R7 done sticky", done_flag, 1);
        pulse_clr();
        check(done_flag == 1'b0, "R7 cleared", done_flag, 0);

        // R4 no ticks, no steps; then fade-out speed 3
        fade_out   = 1'b1;
        fade_speed = 4'd3;
        ms_tick    = 1'b0;
        pulse_go();
        idle(50);
        check(fade_level == 6'd63, "R4 no step without tick", fade_level, 63);
        push_ramp(62, 0, 8);
        mon_on   = 1'b1;
        ms_tick  = 1'b1;
        last_evt = edge_cnt;
        wait_drain();
        mon_on = 1'b0;
        check(done_flag == 1'b1, "R7 done after fade-out", done_flag, 1);
        idle(20);
        check(fade_level == 6'd0, "R5 hold at bottom", fade_level, 0);
        pulse_clr();

        // R1 disable restores full; R2 armed fade-out
        fade_en = 1'b0;
        idle(2);
        check(fade_level == 6'd63, "R1 level disabled", fade_level, 63);
        fade_en = 1'b1;
        idle(2);
        check(fade_level == 6'd63 && force_off == 1'b0, "R2 armed down", fade_level, 63);

        // R9 restart mid-ramp, speed 15
        fade_speed = 4'd15;
        pulse_go();
        repeat (96) @(posedge clk);
        @(negedge clk);
        check(fade_level == 6'd60, "R4 three slow steps", fade_level, 60);
        fade_go = 1'b1;
        @(posedge clk);
        @(negedge clk) fade_go = 1'b0;
        check(fade_level == 6'd63, "R9 restart level", fade_level, 63);
        repeat (31) @(posedge clk);
        @(negedge clk);
        check(fade_level == 6'd63, "R9 interval restarted", fade_level, 63);
        @(posedge clk);
        @(negedge clk);
        check(fade_level == 6'd62, "R9 first step after restart", fade_level, 62);

        // R6 continuous mode, speed 0
        fade_en = 1'b0;
        idle(2);
        fade_en    = 1'b1;
        fade_out   = 1'b0;
        fade_loop  = 1'b1;
        fade_speed = 4'd0;
        idle(2);
        pulse_clr();
        push_ramp(1, 63, 2);
        push_ramp(62, 0, 2);
        push_ramp(1, 1, 2);
        mon_on = 1'b1;
        pulse_go();
        while (exp_q.size() > 64) @(negedge clk);
        check(done_flag == 1'b1, "R6 done at top turn", done_flag, 1);
        pulse_clr();
        wait_drain();
        mon_on = 1'b0;
        check(done_flag == 1'b1, "R6 done at bottom turn", done_flag, 1);

        // R8 clear coincides with final step
        fade_en = 1'b0;
        idle(2);
        fade_loop = 1'b0;
        fade_en   = 1'b1;
        idle(2);
        pulse_clr();
        check(done_flag == 1'b0, "R8 precleared", done_flag, 0);
        pulse_go();
        repeat (125) @(posedge clk);
        @(negedge clk) done_clr = 1'b1;
        @(posedge clk);
        @(negedge clk) done_clr = 1'b0;
        check(fade_level == 6'd63, "R8 final level", fade_level, 63);
        check(done_flag == 1'b1, "R8 set wins over clear", done_flag, 1);
        pulse_clr();
        check(done_flag == 1'b0, "R7 lone clear", done_flag, 0);

        idle(5);
        finish_run();
    end
endmodule